// File: doc/BRIEF.md
# Signed Booth Multiply-Accumulate with Redundant Running Total

This block multiplies two signed 8-bit operands and adds the product to a running total in the same clock cycle. The multiplier operand is recoded in radix-4 Booth digits, so four shifted partial products are formed from the multiplicand. Those partial products are reduced in a carry-save array together with the running total. The total is never resolved inside the loop. It lives in registers as an upper sum vector, an upper carry vector, a two-bit pre-added low field and the carry out of that low field. All of these registers feed straight back into the array.

A second pipeline stage turns the redundant total into an ordinary 20-bit two's complement number. Because the two low bits are already resolved, the adder in that stage only spans the upper 18 bits. A new operand pair can be taken every cycle. A clear strobe given with a pair starts a fresh total from that pair's product, and the result wraps modulo 2^20.

Top module: `booth_csa_mac`

## Requirements
- R1: On each clock edge where `in_vld` is 1 and `in_clr` is 0, the running total becomes the previous total plus the signed product `op_a * op_b`. Both operands are two's complement.
- R2: On a clock edge where `in_vld` and `in_clr` are both 1, the running total becomes exactly the signed product of that pair. Any earlier total is discarded.
- R3: While `in_vld` is 0 the running total does not change. Whenever `acc_vld` is 0, `acc_out` holds the value it had in the previous cycle.
- R4: Suppose a pair is sampled at clock edge e. Then `acc_vld` is 1 and `acc_out` shows the updated total after edge e+1, which is two cycles after the pair was presented. `acc_vld` is 0 in every cycle not tied to an accepted pair in this way.
- R5: The total is 20 bits wide and wraps modulo 2^20 on overflow. `acc_out` is read as a 20-bit two's complement value.
- R6: The extreme operands give exact results: -128 * -128 = +16384 and -128 * 127 = -16256.
- R7: While `rst` is 1 and in the first cycle after it is released, `acc_vld` and `acc_out` are 0. The total is zero after reset, so a first pair with `in_clr` = 0 yields its own product.
- R8: The product is correct for every multiplier value from -128 to 127. This covers each Booth digit (0, +1, +2, -1, -2) in each of the four digit positions, for positive, negative and extreme multiplicands.
- R9: Pairs presented on consecutive cycles with no gaps are each accumulated once, and each gives its own result two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand pair is present this cycle |
| in_clr | input | 1 | With `in_vld`: start a new total from this product |
| op_a | input | 8 | Signed multiplicand |
| op_b | input | 8 | Signed multiplier (Booth recoded) |
| acc_vld | output | 1 | `acc_out` carries a freshly updated total |
| acc_out | output | 20 | Resolved running total, two's complement |

## Verification
Full sweeps of the multiplier against fixed multiplicands of both signs, including -128, exercise every Booth digit in every row. Any fault in recoding, inversion, the correction bits or the sign-handling constant shows up as a wrong single product. Long runs of alternating-sign products keep the carry and low-field feedback busy without growing the total. A repeated large positive product drives the total past 2^19 and shows whether the wrap is modulo 2^20. Isolated pairs, gapped streams and clear strobes in the middle of a run separate the two-cycle latency, the hold-while-idle rule and the load-versus-add choice from one another.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int OPW  = 8;
    localparam int ACCW = 20;
    localparam int LOWW = 2;
    localparam int NPP  = OPW / 2;
    localparam int PPW  = OPW + 1;
    localparam int HIW  = ACCW - LOWW;
    localparam int NOPS = 4 + NPP;

    // Folded sign-handling constant: minus the weight of each row's sign position
    function automatic logic [ACCW-1:0] sign_const();
        logic [ACCW-1:0] r;
        r = '0;
        for (int j = 0; j < NPP; j++) begin
            r = r - (ACCW'(1) << (PPW - 1 + 2 * j));
        end
        return r;
    endfunction

    typedef struct packed {
        logic [HIW-1:0]  s_hi;
        logic [HIW-1:0]  c_hi;
        logic [LOWW-1:0] z;
        logic            k;
        logic            pvld;
        logic [ACCW-1:0] res;
        logic            ovld;
    } mac_state_t;
endpackage

// File: rtl/mac_booth_row.sv
module mac_booth_row #(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0] mcand,
    input  logic [2:0]     trip,
    output logic [OPW:0]   row,
    output logic           neg
);
    logic         one;
    logic         two;
    logic [OPW:0] mag;
    logic [OPW:0] v;

    always_comb begin
        one = trip[0] ^ trip[1];
        two = (trip == 3'b011) || (trip == 3'b100);
        neg = trip[2] & ~(trip[1] & trip[0]);
        if (one)      mag = {mcand[OPW-1], mcand};
        else if (two) mag = {mcand, 1'b0};
        else          mag = '0;
        v   = neg ? ~mag : mag;
        // sign bit inverted; the constant in the array removes the offset
        row = {~v[OPW], v[OPW-1:0]};
    end
endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree #(
    parameter int W = 20,
    parameter int N = 8
) (
    input  logic [N-1:0][W-1:0] ops,
    output logic [W-1:0]        sum,
    output logic [W-1:0]        carry
);
    logic [N-2:0][W-1:0] s;
    logic [N-2:0][W-1:0] c;

    assign s[0] = ops[0];
    assign c[0] = ops[1];

    for (genvar i = 0; i < N - 2; i++) begin : g_row
        logic [W-1:0] maj;
        assign maj      = (s[i] & c[i]) | (s[i] & ops[i+2]) | (c[i] & ops[i+2]);
        assign s[i+1]   = s[i] ^ c[i] ^ ops[i+2];
        assign c[i+1]   = {maj[W-2:0], 1'b0};
    end

    assign sum   = s[N-2];
    assign carry = c[N-2];
endmodule

// File: rtl/mac_low_cla.sv
module mac_low_cla #(
    parameter int LW = 2
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic          cin,
    output logic [LW-1:0] z,
    output logic          cout
);
    logic [LW-1:0] g;
    logic [LW-1:0] p;
    logic [LW:0]   cy;

    assign g     = a & b;
    assign p     = a ^ b;
    assign cy[0] = cin;
    for (genvar i = 0; i < LW; i++) begin : g_la
        assign cy[i+1] = g[i] | (p[i] & cy[i]);
    end
    assign z    = p ^ cy[LW-1:0];
    assign cout = cy[LW];
endmodule

// File: rtl/mac_final_add.sv
module mac_final_add #(
    parameter int HW = 18
) (
    input  logic [HW-1:0] a,
    input  logic [HW-1:0] b,
    input  logic          cin,
    output logic [HW-1:0] s
);
    assign s = a + b + HW'(cin);
endmodule

// File: rtl/booth_csa_mac.sv
module booth_csa_mac
    import mac_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic            in_clr,
    input  logic [OPW-1:0]  op_a,
    input  logic [OPW-1:0]  op_b,
    output logic            acc_vld,
    output logic [ACCW-1:0] acc_out
);
    localparam logic [ACCW-1:0] SIGN_K = sign_const();

    mac_state_t st_q, st_d;

    logic [OPW:0]              b_ext;
    logic [NPP-1:0][PPW-1:0]   rows;
    logic [NPP-1:0]            negs;
    logic [NOPS-1:0][ACCW-1:0] ops;
    logic [ACCW-1:0]           t_sum;
    logic [ACCW-1:0]           t_carry;
    logic [LOWW-1:0]           z_new;
    logic                      k_new;
    logic [HIW-1:0]            hi_sum;
    logic                      fb_en;

    assign b_ext = {op_b, 1'b0};
    assign fb_en = ~in_clr;

    for (genvar j = 0; j < NPP; j++) begin : g_pp
        mac_booth_row #(.OPW(OPW)) u_row (
            .mcand (op_a),
            .trip  (b_ext[2*j+2:2*j]),
            .row   (rows[j]),
            .neg   (negs[j])
        );
    end

    always_comb begin
        ops[0] = fb_en ? {st_q.s_hi, st_q.z} : '0;
        ops[1] = fb_en ? {st_q.c_hi, {LOWW{1'b0}}} : '0;
        ops[2] = ACCW'(fb_en & st_q.k) << LOWW;
        ops[3] = SIGN_K;
        for (int j = 1; j < NPP; j++) begin
            ops[3][2*j] = negs[j];
        end
        for (int j = 0; j < NPP; j++) begin
            ops[4+j] = ACCW'(rows[j]) << (2 * j);
        end
    end

    mac_csa_tree #(.W(ACCW), .N(NOPS)) u_tree (
        .ops   (ops),
        .sum   (t_sum),
        .carry (t_carry)
    );

    // row 0 correction bit enters as the low adder's carry input
    mac_low_cla #(.LW(LOWW)) u_low (
        .a    (t_sum[LOWW-1:0]),
        .b    (t_carry[LOWW-1:0]),
        .cin  (negs[0]),
        .z    (z_new),
        .cout (k_new)
    );

    mac_final_add #(.HW(HIW)) u_fin (
        .a   (st_q.s_hi),
        .b   (st_q.c_hi),
        .cin (st_q.k),
        .s   (hi_sum)
    );

    always_comb begin
        st_d = st_q;
        if (in_vld) begin
            st_d.s_hi = t_sum[ACCW-1:LOWW];
            st_d.c_hi = t_carry[ACCW-1:LOWW];
            st_d.z    = z_new;
            st_d.k    = k_new;
        end
        st_d.pvld = in_vld;
        st_d.ovld = st_q.pvld;
        if (st_q.pvld) begin
            st_d.res = {hi_sum, st_q.z};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_vld = st_q.ovld;
    assign acc_out = st_q.res;
endmodule

// File: rtl/mac_chk.sv
module mac_chk
    import mac_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_vld,
    input logic            in_clr,
    input logic [OPW-1:0]  op_a,
    input logic [OPW-1:0]  op_b,
    input logic            acc_vld,
    input logic [ACCW-1:0] acc_out
);
    logic signed [2*OPW-1:0] prod;
    logic [ACCW-1:0]         prod_x;
    logic [ACCW-1:0]         tot_q, nxt;
    logic                    v1, v2, c1, c2;
    logic [ACCW-1:0]         e1, e2, p1, p2;

    assign prod   = $signed(op_a) * $signed(op_b);
    assign prod_x = ACCW'(prod);
    assign nxt    = (in_clr ? '0 : tot_q) + prod_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_q <= '0; v1 <= 1'b0; v2 <= 1'b0; c1 <= 1'b0; c2 <= 1'b0;
            e1 <= '0; e2 <= '0; p1 <= '0; p2 <= '0;
        end else begin
            if (in_vld) tot_q <= nxt;
            v1 <= in_vld;
            c1 <= in_vld & in_clr;
            e1 <= in_vld ? nxt : tot_q;
            p1 <= prod_x;
            v2 <= v1; c2 <= c1; e2 <= e1; p2 <= p1;
        end
    end

    // R4
    latency_vld_chk: assert property (@(posedge clk) disable iff (rst)
        acc_vld == v2);

    // R1
    running_sum_chk: assert property (@(posedge clk) disable iff (rst)
        acc_vld |-> (acc_out == e2));

    // R2
    clear_load_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && c2) |-> (acc_out == p2));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_vld |-> $stable(acc_out));

    // R7
    reset_out_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!acc_vld && acc_out == '0));
endmodule

bind booth_csa_mac mac_chk u_chk (.*);

// File: tb/sim_booth_csa_mac.sv
module sim_booth_csa_mac;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic        in_clr = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic        acc_vld;
    logic [19:0] acc_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [19:0] acc = '0;
    logic [19:0] hold = '0;
    logic        v1 = 0, v2 = 0;
    logic [19:0] e1 = '0, e2 = '0;
    string       t1 = "", t2 = "";

    always #5 clk = ~clk;

    booth_csa_mac u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_clr(in_clr),
        .op_a(op_a), .op_b(op_b), .acc_vld(acc_vld), .acc_out(acc_out)
    );

    task automatic check_out();
        n_cmp++;
        if (v2) begin
            if (acc_vld !== 1'b1 || acc_out !== e2) begin
                n_bad++;
                $display("FAIL %s R4: vld=%0d out=%h expected vld=1 out=%h",
                         t2, acc_vld, acc_out, e2);
            end
            hold = e2;
        end else begin
            if (acc_vld !== 1'b0 || acc_out !== hold) begin
                n_bad++;
                $display("FAIL %s R3: vld=%0d out=%h expected vld=0 out=%h",
                         t2, acc_vld, acc_out, hold);
            end
        end
    endtask

    task automatic step(input logic v, input logic c,
                        input logic [7:0] a, input logic [7:0] b, input string tag);
        logic signed [15:0] pr;
        @(negedge clk);
        check_out();
        if (v) begin
            pr  = $signed({{8{a[7]}}, a}) * $signed({{8{b[7]}}, b});
            acc = (c ? 20'd0 : acc) + {{4{pr[15]}}, pr};
        end
        in_vld = v; in_clr = c; op_a = a; op_b = b;
        v2 = v1; e2 = e1; t2 = t1;
        v1 = v; e1 = acc; t1 = tag;
    endtask

    task automatic drain();
        step(0, 0, 8'h00, 8'h00, "drain R3");
        step(0, 0, 8'h00, 8'h00, "drain R3");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (acc_vld !== 1'b0 || acc_out !== 20'd0) begin
            n_bad++;
            $display("FAIL R7 reset: vld=%0d out=%h expected vld=0 out=0", acc_vld, acc_out);
        end
        rst = 1'b0;
        acc = '0; hold = '0; v1 = 0; v2 = 0;
    endtask

    task automatic t_first_after_reset();
        step(1, 0, 8'd7, 8'hFB, "R7 first pair no clear");
        drain();
    endtask

    task automatic t_isolated();
        step(1, 0, 8'd3, 8'd5, "R4 isolated");
        step(0, 0, 8'h55, 8'hAA, "R3 idle ignored");
        step(0, 1, 8'h12, 8'h34, "R3 idle clr ignored");
        step(0, 0, 8'h00, 8'h00, "R3 idle");
        step(1, 0, 8'hF0, 8'd9, "R1 add after gap");
        drain();
    endtask

    task automatic t_clear();
        step(1, 0, 8'd100, 8'd100, "R1 build");
        step(1, 0, 8'd50, 8'd60, "R1 build");
        step(1, 1, 8'hF6, 8'd11, "R2 clear load");
        step(1, 0, 8'd2, 8'd2, "R1 add after clear");
        step(1, 1, 8'd0, 8'd0, "R2 clear to zero");
        drain();
    endtask

    task automatic t_extremes();
        step(1, 1, 8'h80, 8'h80, "R6 -128*-128");
        step(1, 1, 8'h80, 8'h7F, "R6 -128*127");
        step(1, 1, 8'h7F, 8'h80, "R6 127*-128");
        step(1, 1, 8'h7F, 8'h7F, "R6 127*127");
        step(1, 1, 8'hFF, 8'hFF, "R6 -1*-1");
        drain();
    endtask

    task automatic t_sweep();
        logic [7:0] mc [4];
        mc[0] = 8'h5B; mc[1] = 8'hA7; mc[2] = 8'h80; mc[3] = 8'h7F;
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 256; b++) begin
                step(1, 1, mc[m], 8'(b), "R8 multiplier sweep");
            end
        end
        for (int a = 0; a < 256; a++) begin
            step(1, 0, 8'(a), 8'hC5, "R9 back-to-back multiplicand sweep");
        end
        drain();
    endtask

    task automatic t_alternating();
        step(1, 1, 8'd0, 8'd0, "R2 start");
        for (int i = 0; i < 300; i++) begin
            if (i % 2 == 0) step(1, 0, 8'(i * 37 + 3), 8'(i * 11 + 90), "R1 alternating +");
            else            step(1, 0, 8'(i * 37 + 3), 8'(-(i * 11 + 90)), "R1 alternating -");
        end
        drain();
    endtask

    task automatic t_wrap();
        step(1, 1, 8'h7F, 8'h7F, "R5 start");
        for (int i = 0; i < 60; i++) begin
            step(1, 0, 8'h7F, 8'h7F, "R5 wrap past 2^19");
        end
        for (int i = 0; i < 60; i++) begin
            step(1, 0, 8'h80, 8'h7F, "R5 wrap negative");
        end
        drain();
    endtask

    task automatic t_gapped();
        for (int i = 0; i < 40; i++) begin
            step(1, 0, 8'(i * 13 - 60), 8'(i * 29 + 5), "R9 gapped stream");
            if (i % 3 == 0) step(0, 0, 8'hFF, 8'hFF, "R3 gap");
        end
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_after_reset();
        t_isolated();
        t_clear();
        t_extremes();
        t_sweep();
        t_alternating();
        t_wrap();
        t_gapped();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule